// File: doc/BRIEF.md
# Drum Memory Self-Test Sequencer

This block runs the built-in write-then-verify test of a rotating drum memory module. When the test enable is raised it walks eight word patterns. For each pattern it sweeps the data tracks from track 0 up to a last tested track. On every track it runs one write pass and then one read pass at a raised detection threshold. A pass is a fixed number of word-clock strobes. The drum head and the read channel lie outside the block: each word's compare result arrives on an input, valid together with the word strobe.

The read pass has a report word. At that word the sequencer decides whether to report. It reports when a mismatch was seen up to and including that word, when a forced error is still owed, or when an earlier error has not been acknowledged. To report, it pulses the error output, holds the sweep, and after a set delay shifts a 32-bit status word out as four strobed bytes, most significant byte first. A sector-end pulse from the controller acknowledges the error. Until that pulse arrives, every later read pass repeats the report. A preset number of forced errors can be loaded at start so that the controller's error path can be exercised with known status words. After the read pass of the eighth pattern on the last tested track, a single completion pulse is issued.

Top module: `drum_selftest_seq`

## Requirements
- R1: Raising `test_en` from idle starts the sweep at pattern 0, track 0, write pass. Lowering `test_en` aborts the test within one cycle: no further error, strobe or done pulses occur, and the next enable restarts from pattern 0, track 0.
- R2: Passes run in this order: on each track a write pass, then a read pass. Tracks go from 0 to `LAST_TRACK`. After the last track the pattern index advances and the track returns to 0. There are eight patterns, 0 to 7.
- R3: A pass is `WORDS_PER_PASS` accepted word strobes. `rd_mismatch` is sampled only on word strobes 1 to `REPORT_WORD` (counted from 1) of a read pass. A mismatch in a write pass, or after the report word, has no effect.
- R4: When a report is due, `test_error` is high for exactly one cycle: the cycle right after the clock edge that accepts the `REPORT_WORD`-th strobe of the read pass.
- R5: A report emits four one-cycle `byte_strobe` pulses. The first comes `STROBE_DELAY` cycles after the `test_error` cycle, and each later one `STROBE_GAP` cycles after the one before. `status_byte` carries status bits 31:24, 23:16, 15:8 and 7:0 in that order. Status layout: bits 8:0 track, bits 11:9 pattern, bit 12 real mismatch, bit 13 forced error, all other bits zero.
- R6: Word strobes that arrive from the `test_error` cycle through the last byte-strobe cycle are ignored. Counting resumes in the cycle after the last byte strobe.
- R7: After a report, and until a `sector_end` pulse, every later read pass reports at its report word. If that pass has no new error, the report repeats the last captured status word. A `sector_end` pulse clears this repetition.
- R8: `force_count` is sampled when the test starts. The first `force_count` read passes each report a forced error, with status bit 13 set.
- R9: `test_done` is high for exactly one cycle: the cycle after the last word of the pattern-7 read pass on `LAST_TRACK`. After that, word strobes produce no output until `test_en` is lowered.
- R10: While reset is held, and after reset with `test_en` low, `test_error`, `byte_strobe`, `test_done` and `status_byte` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Test enable; rising starts, falling aborts |
| word_clk | input | 1 | One-cycle strobe per drum word |
| rd_mismatch | input | 1 | Compare result for the current word, valid with `word_clk` |
| sector_end | input | 1 | Error acknowledge pulse from the controller |
| force_count | input | FORCE_W | Number of forced errors for this run |
| test_error | output | 1 | One-cycle error pulse |
| byte_strobe | output | 1 | Status byte valid strobe |
| status_byte | output | 8 | Status byte, most significant first |
| test_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a report repeated because nobody acknowledged it. It only appears when an error is left without a `sector_end`, and then a later read pass that has no mismatch of its own must still report the old status word with the right timing. The stimulus table places a mismatch on one read pass and sends no acknowledge. It checks that the next read pass repeats the same bytes, and then acknowledges after that repeat. A second run loads forced errors, drives a word strobe in the middle of a report, and leaves the last forced error unacknowledged. If the stray word were counted, every later report word would shift, so a miscount shows up as a wrongly timed error pulse.

// File: rtl/drum_selftest_pkg.sv
package drum_selftest_pkg;

  localparam int PAT_W  = 3;
  localparam int STAT_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_REPORT = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_t;

endpackage

// File: rtl/drum_word_tracker.sv
module drum_word_tracker #(
  parameter int WORDS_PER_PASS = 1250,
  parameter int REPORT_WORD    = 1241,
  parameter int LAST_TRACK     = 383,
  parameter int TRACK_W        = 9,
  parameter int PAT_W          = 3
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  clear,
  input  logic                                  step,
  output logic [$clog2(WORDS_PER_PASS+1)-1:0]   word_idx,
  output logic                                  is_read,
  output logic [TRACK_W-1:0]                    track,
  output logic [PAT_W-1:0]                      pattern,
  output logic                                  at_report,
  output logic                                  pass_end,
  output logic                                  final_pass
);

  localparam int WORD_W  = $clog2(WORDS_PER_PASS+1);
  localparam int NUM_PAT = 1 << PAT_W;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      word_idx <= '0;
      is_read  <= 1'b0;
      track    <= '0;
      pattern  <= '0;
    end else if (step) begin
      if (word_idx == WORD_W'(WORDS_PER_PASS-1)) begin
        word_idx <= '0;
        if (!is_read) begin
          is_read <= 1'b1;
        end else begin
          is_read <= 1'b0;
          if (track == TRACK_W'(LAST_TRACK)) begin
            track   <= '0;
            pattern <= pattern + 1'b1;
          end else begin
            track <= track + 1'b1;
          end
        end
      end else begin
        word_idx <= word_idx + 1'b1;
      end
    end
  end

  always_comb begin
    at_report  = step && is_read && (word_idx == WORD_W'(REPORT_WORD-1));
    pass_end   = step && (word_idx == WORD_W'(WORDS_PER_PASS-1));
    final_pass = is_read && (track == TRACK_W'(LAST_TRACK)) &&
                 (pattern == PAT_W'(NUM_PAT-1));
  end

  p_track_bound_r2: assert property (@(posedge clk) disable iff (rst)
    track <= TRACK_W'(LAST_TRACK));

  p_read_after_write_r2: assert property (@(posedge clk) disable iff (rst || clear)
    (pass_end && !is_read) |=> is_read);

endmodule

// File: rtl/drum_force_budget.sv
module drum_force_budget #(
  parameter int FORCE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FORCE_W-1:0] load_val,
  input  logic               use_one,
  output logic               nonzero
);

  logic [FORCE_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (use_one && (remain != '0)) begin
      remain <= remain - 1'b1;
    end
  end

  assign nonzero = (remain != '0);

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    (use_one && !load) |-> (remain != '0));

endmodule

// File: rtl/drum_status_shifter.sv
module drum_status_shifter #(
  parameter int STAT_W       = 32,
  parameter int STROBE_DELAY = 4,
  parameter int STROBE_GAP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              start,
  input  logic [STAT_W-1:0] word_in,
  output logic              busy,
  output logic              strobe,
  output logic [7:0]        byte_out
);

  localparam int NBYTES = STAT_W / 8;
  localparam int MAXW   = (STROBE_DELAY > STROBE_GAP) ? STROBE_DELAY : STROBE_GAP;
  localparam int CNT_W  = $clog2(MAXW + 1);
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic              active;
  logic [CNT_W-1:0]  wait_cnt;
  logic [IDX_W-1:0]  idx;
  logic [STAT_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      active   <= 1'b0;
      strobe   <= 1'b0;
      byte_out <= '0;
      wait_cnt <= '0;
      idx      <= '0;
      sreg     <= '0;
    end else begin
      strobe <= 1'b0;
      if (start) begin
        active   <= 1'b1;
        sreg     <= word_in;
        wait_cnt <= CNT_W'(STROBE_DELAY);
        idx      <= '0;
      end else if (active) begin
        if (wait_cnt == CNT_W'(1)) begin
          strobe   <= 1'b1;
          byte_out <= sreg[STAT_W-1 -: 8];
          sreg     <= sreg << 8;
          if (idx == IDX_W'(NBYTES-1)) begin
            active <= 1'b0;
          end else begin
            idx      <= idx + 1'b1;
            wait_cnt <= CNT_W'(STROBE_GAP);
          end
        end else begin
          wait_cnt <= wait_cnt - 1'b1;
        end
      end
    end
  end

  assign busy = active;

  p_strobe_from_active_r5: assert property (@(posedge clk) disable iff (rst || flush)
    strobe |-> $past(active));

  p_start_when_idle_r6: assert property (@(posedge clk) disable iff (rst || flush)
    start |-> !active);

endmodule

// File: rtl/drum_selftest_seq.sv
module drum_selftest_seq
  import drum_selftest_pkg::*;
#(
  parameter int WORDS_PER_PASS = 1250,
  parameter int REPORT_WORD    = 1241,
  parameter int LAST_TRACK     = 383,
  parameter int TRACK_W        = 9,
  parameter int FORCE_W        = 4,
  parameter int STROBE_DELAY   = 4,
  parameter int STROBE_GAP     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               test_en,
  input  logic               word_clk,
  input  logic               rd_mismatch,
  input  logic               sector_end,
  input  logic [FORCE_W-1:0] force_count,
  output logic               test_error,
  output logic               byte_strobe,
  output logic [7:0]         status_byte,
  output logic               test_done
);

  localparam int WORD_W = $clog2(WORDS_PER_PASS+1);

  seq_state_t state;

  logic              start_run;
  logic              accept;
  logic [WORD_W-1:0] word_idx;
  logic              is_read;
  logic [TRACK_W-1:0] track;
  logic [PAT_W-1:0]  pattern;
  logic              at_report;
  logic              pass_end;
  logic              final_pass;
  logic              forced_due;
  logic              mism_now;
  logic              mism_seen;
  logic              real_err;
  logic              new_err;
  logic              trigger;
  logic              pending;
  logic              shift_busy;
  logic [STAT_W-1:0] held_status;
  logic [STAT_W-1:0] status_word;

  assign start_run = (state == ST_IDLE) && test_en;
  assign accept    = (state == ST_RUN) && test_en && word_clk;

  drum_word_tracker #(
    .WORDS_PER_PASS (WORDS_PER_PASS),
    .REPORT_WORD    (REPORT_WORD),
    .LAST_TRACK     (LAST_TRACK),
    .TRACK_W        (TRACK_W),
    .PAT_W          (PAT_W)
  ) u_tracker (
    .clk        (clk),
    .rst        (rst),
    .clear      (start_run),
    .step       (accept),
    .word_idx   (word_idx),
    .is_read    (is_read),
    .track      (track),
    .pattern    (pattern),
    .at_report  (at_report),
    .pass_end   (pass_end),
    .final_pass (final_pass)
  );

  drum_force_budget #(
    .FORCE_W (FORCE_W)
  ) u_budget (
    .clk      (clk),
    .rst      (rst),
    .load     (start_run),
    .load_val (force_count),
    .use_one  (at_report && forced_due),
    .nonzero  (forced_due)
  );

  // mismatch counts only on read words 1..REPORT_WORD
  assign mism_now = accept && is_read && rd_mismatch &&
                    (word_idx < WORD_W'(REPORT_WORD));
  assign real_err = mism_seen || mism_now;
  assign new_err  = real_err || forced_due;
  assign trigger  = at_report && (new_err || pending);

  always_comb begin
    status_word = held_status;
    if (new_err) begin
      status_word = STAT_W'({forced_due, real_err, pattern, track});
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start_run) begin
      mism_seen <= 1'b0;
    end else if (pass_end) begin
      mism_seen <= 1'b0;
    end else if (mism_now) begin
      mism_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start_run) begin
      pending     <= 1'b0;
      held_status <= '0;
    end else begin
      if (trigger) begin
        pending     <= 1'b1;
        held_status <= status_word;
      end else if (sector_end && (state == ST_RUN || state == ST_REPORT)) begin
        pending <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      test_error <= 1'b0;
      test_done  <= 1'b0;
    end else begin
      test_error <= trigger;
      test_done  <= accept && pass_end && final_pass;
      if (state != ST_IDLE && !test_en) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE:   if (test_en) state <= ST_RUN;
          ST_RUN: begin
            if (trigger) begin
              state <= ST_REPORT;
            end else if (accept && pass_end && final_pass) begin
              state <= ST_DONE;
            end
          end
          ST_REPORT: if (!shift_busy) state <= ST_RUN;
          ST_DONE:   state <= ST_DONE;
          default:   state <= ST_IDLE;
        endcase
      end
    end
  end

  drum_status_shifter #(
    .STAT_W       (STAT_W),
    .STROBE_DELAY (STROBE_DELAY),
    .STROBE_GAP   (STROBE_GAP)
  ) u_shifter (
    .clk      (clk),
    .rst      (rst),
    .flush    (!test_en),
    .start    (trigger),
    .word_in  (status_word),
    .busy     (shift_busy),
    .strobe   (byte_strobe),
    .byte_out (status_byte)
  );

  p_err_single_r4: assert property (@(posedge clk) disable iff (rst)
    test_error |=> !test_error);

  p_err_opens_report_r4: assert property (@(posedge clk) disable iff (rst || !test_en)
    test_error |-> shift_busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    test_done |=> !test_done);

  p_hold_in_report_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REPORT && $past(state) == ST_REPORT) |-> $stable(word_idx));

endmodule

// File: tb/drum_selftest_seq_tb.sv
`timescale 1ns/1ps
module drum_selftest_seq_tb;

  localparam int WORDS  = 4;
  localparam int REPW   = 3;
  localparam int LASTT  = 2;
  localparam int DELAY  = 3;
  localparam int GAP    = 2;
  localparam int FW     = 4;

  typedef struct packed {
    logic [2:0] pat;
    logic [8:0] trk;
    logic       rd;
    logic [2:0] word;
    logic       ack;
  } vec_t;

  // mismatch placements; word is 1-based, ack = sector_end after that pass's report
  localparam vec_t VECS [6] = '{
    '{3'd0, 9'd1, 1'b1, 3'd2, 1'b0},
    '{3'd0, 9'd2, 1'b1, 3'd0, 1'b1},
    '{3'd2, 9'd1, 1'b0, 3'd2, 1'b0},
    '{3'd3, 9'd0, 1'b1, 3'd4, 1'b0},
    '{3'd5, 9'd2, 1'b1, 3'd3, 1'b1},
    '{3'd7, 9'd2, 1'b1, 3'd1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic test_en = 1'b0;
  logic word_clk = 1'b0;
  logic rd_mismatch = 1'b0;
  logic sector_end = 1'b0;
  logic [FW-1:0] force_count = '0;
  logic test_error, byte_strobe, test_done;
  logic [7:0] status_byte;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  drum_selftest_seq #(
    .WORDS_PER_PASS (WORDS),
    .REPORT_WORD    (REPW),
    .LAST_TRACK     (LASTT),
    .TRACK_W        (9),
    .FORCE_W        (FW),
    .STROBE_DELAY   (DELAY),
    .STROBE_GAP     (GAP)
  ) u_dut (
    .clk         (clk),
    .rst         (rst),
    .test_en     (test_en),
    .word_clk    (word_clk),
    .rd_mismatch (rd_mismatch),
    .sector_end  (sector_end),
    .force_count (force_count),
    .test_error  (test_error),
    .byte_strobe (byte_strobe),
    .status_byte (status_byte),
    .test_done   (test_done)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic pulse_sector_end();
    @(negedge clk); sector_end = 1'b1;
    @(negedge clk); sector_end = 1'b0;
  endtask

  task automatic do_word(input logic m, input bit trig, input logic [31:0] st,
                         input bit fin, input bit inj, input string tag);
    int nb;
    bit es;
    @(negedge clk); word_clk = 1'b1; rd_mismatch = m;
    @(negedge clk); word_clk = 1'b0; rd_mismatch = 1'b0;
    chk(test_error === trig, {"R4 ", tag, " error pulse"}, 32'(test_error), 32'(trig));
    chk(test_done === fin, {"R9 ", tag, " done pulse"}, 32'(test_done), 32'(fin));
    if (trig) begin
      nb = 0;
      for (int off = 1; off <= DELAY + 3*GAP; off++) begin
        @(negedge clk);
        es = (off >= DELAY) && (((off - DELAY) % GAP) == 0);
        chk(byte_strobe === es, {"R5 ", tag, " strobe timing"}, 32'(byte_strobe), 32'(es));
        if (es) begin
          chk(status_byte === st[31-8*nb -: 8], {"R5 ", tag, " status byte"},
              32'(status_byte), 32'(st[31-8*nb -: 8]));
          nb++;
        end
        if (inj && off == 1) begin
          chk(test_error === 1'b0, "R6 no second pulse", 32'(test_error), 32'd0);
          word_clk = 1'b1;
        end
        if (inj && off == 2) word_clk = 1'b0;
      end
    end
  endtask

  // Walks the pass sequence and predicts every output from the requirements.
  task automatic run_seq(input int force_n, input int stop_passes, input bit use_tab, input string tag_new);
    bit pending = 1'b0;
    int budget = force_n;
    logic [31:0] held = '0;
    int passes = 0;
    bit first_force = 1'b1;
    @(negedge clk); force_count = FW'(force_n); test_en = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 8; p++) begin
      for (int t = 0; t <= LASTT; t++) begin
        for (int rd = 0; rd < 2; rd++) begin
          int mw = 0;
          bit ack = 1'b0;
          bit latch = 1'b0;
          bit did_trig = 1'b0;
          if (stop_passes > 0 && passes == stop_passes) return;
          if (use_tab) begin
            for (int k = 0; k < 6; k++) begin
              if (VECS[k].pat == 3'(p) && VECS[k].trk == 9'(t) && VECS[k].rd == rd[0]) begin
                mw  = int'(VECS[k].word);
                ack = VECS[k].ack;
              end
            end
          end
          for (int w = 1; w <= WORDS; w++) begin
            bit m = (w == mw);
            bit trig = 1'b0;
            bit inj = 1'b0;
            bit fin;
            string tag = "R3";
            if (rd == 1 && m && w <= REPW) latch = 1'b1;
            if (rd == 1 && w == REPW && (latch || budget > 0 || pending)) begin
              trig = 1'b1;
              if (latch || budget > 0) begin
                held = {18'd0, (budget > 0), latch, 3'(p), 9'(t)};
                tag = tag_new;
                if (budget > 0) begin
                  budget--;
                  inj = first_force;
                  if (first_force) tag = "R6";
                  first_force = 1'b0;
                end
              end else begin
                tag = "R7";
              end
              pending = 1'b1;
              did_trig = 1'b1;
            end
            fin = (rd == 1 && p == 7 && t == LASTT && w == WORDS);
            if (fin) tag = "R9";
            do_word(m, trig, held, fin, inj, tag);
          end
          if (did_trig && ack) begin
            pulse_sector_end();
            pending = 1'b0;
          end
          passes++;
        end
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(test_error === 1'b0 && byte_strobe === 1'b0 && test_done === 1'b0 && status_byte === 8'd0,
        "R10 outputs in reset", {test_error, byte_strobe, test_done, status_byte}, 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); word_clk = 1'b1; rd_mismatch = 1'b1;
      @(negedge clk); word_clk = 1'b0; rd_mismatch = 1'b0;
      chk(test_error === 1'b0 && byte_strobe === 1'b0 && test_done === 1'b0 && status_byte === 8'd0,
          "R10 outputs idle while disabled", {test_error, byte_strobe, test_done, status_byte}, 32'd0);
    end

    // Table-driven full run (R2, R3, R5, R7, R9)
    run_seq(0, 0, 1'b1, "R2");

    // R9: after completion, word strobes are ignored
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); word_clk = 1'b1; rd_mismatch = 1'b1;
      @(negedge clk); word_clk = 1'b0; rd_mismatch = 1'b0;
      chk(test_error === 1'b0 && test_done === 1'b0 && byte_strobe === 1'b0,
          "R9 quiet after done", {test_error, test_done, byte_strobe}, 32'd0);
    end
    @(negedge clk); test_en = 1'b0;
    @(negedge clk);

    // Forced errors with a stray word strobe during the first report (R8, R6, R7)
    run_seq(2, 6, 1'b0, "R8");

    // R1: abort mid-run
    @(negedge clk); test_en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); word_clk = i[0]; rd_mismatch = 1'b1;
      chk(test_error === 1'b0 && byte_strobe === 1'b0 && test_done === 1'b0,
          "R1 silent after abort", {test_error, byte_strobe, test_done}, 32'd0);
    end
    word_clk = 1'b0; rd_mismatch = 1'b0;
    @(negedge clk);

    // R1: restart begins at pattern 0 track 0
    run_seq(1, 2, 1'b0, "R1");
    @(negedge clk); test_en = 1'b0;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule